// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Encoder

This block gathers the interrupt conditions of a UART and turns them into one interrupt line and an identification byte that software reads to learn which condition to service first. Five sources are considered: receiver line errors, received data at or above the trigger level, receive character timeout, transmit holding empty and modem status changes. Each source is gated by its own enable. Only the highest-priority pending source is reported.

The receive-data source compares the receive occupancy against a trigger level. In FIFO mode the level is chosen by a two-bit code. In single-buffer mode any held character counts. The transmit-empty source is an event flag. It is set when the transmitter becomes empty while its enable is on, and it is dropped by a load into the transmitter or by a read of the identification byte. The timeout source counts character-time ticks during which the receive FIFO is non-empty and sees neither a push nor a pop.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with all inputs idle and single-buffer mode, the identification byte is 0x01 and `irq` is 0.
- R2: While all four enables are 0, bit 0 of the identification byte stays 1 and `irq` stays 0 whatever the source conditions are.
- R3: If `en_line` is 1 and any bit of `line_flags` is set (bit0 overrun, bit1 parity, bit2 framing, bit3 break), the type code in bits [3:1] is 3. This source outranks all other sources.
- R4: In FIFO mode with `en_rx_data` set, type code 2 is reported while `rx_level` is at or above the trigger level. Trigger codes 0, 1, 2 and 3 select 1, 4, 8 and 14 entries.
- R5: In single-buffer mode with `en_rx_data` set, type code 2 is reported while `rx_level` is non-zero. The trigger code has no effect in this mode.
- R6: In FIFO mode with `en_rx_data` set and `rx_level` non-zero, type code 6 appears after TMO_CHARS (4) `char_tick` pulses with no `rx_push` or `rx_pop`. A push or pop clears it. Type code 2 outranks it.
- R7: Type code 1 appears one cycle after `tx_empty` and `en_tx_empty` are both 1, counted from the cycle in which the second of the two became 1. A `tx_load` clears it, and so does an `iir_rd` pulse. After a read-clear it stays clear until `tx_empty` falls and rises again.
- R8: With `en_modem` set, type code 0 is reported with the pending bit at 0 when any of `modem_delta[3:1]` is set. The same holds for `modem_delta[0]` (the CTS change) only when `afe_en` is 0. This source has the lowest priority.
- R9: Bits [7:6] of the identification byte read 2'b11 in FIFO mode and 2'b00 otherwise. Bits [5:4] read 0.
- R10: `irq` is 1 exactly when bit 0 of the identification byte is 0. With nothing pending, bits [3:1] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_rx_data | input | 1 | Enable for the receive data and timeout sources |
| en_tx_empty | input | 1 | Enable for the transmit-empty source |
| en_line | input | 1 | Enable for the line error source |
| en_modem | input | 1 | Enable for the modem status source |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| trig_code | input | 2 | Receive trigger level select |
| rx_level | input | LVL_W | Receive occupancy count |
| rx_push | input | 1 | A character entered the receive buffer |
| rx_pop | input | 1 | A character was read from the receive buffer |
| char_tick | input | 1 | One pulse per character time |
| line_flags | input | 4 | Overrun, parity, framing and break conditions |
| tx_empty | input | 1 | Transmit holding register or FIFO is empty |
| tx_load | input | 1 | A character was written to the transmitter |
| iir_rd | input | 1 | Identification byte read strobe |
| modem_delta | input | 4 | Modem change flags; bit0 is the CTS change |
| afe_en | input | 1 | Autoflow control active |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Active-high interrupt line |

## Verification
The bench builds the block with LVL_W = 5 and TMO_CHARS = 4. With these values every receive occupancy from 0 to 16 can be driven, so each trigger threshold is hit exactly, and also one entry below and one above it. A full sweep covers all enable masks, both modes, all trigger codes, every level, line errors on or off, and the modem patterns with and without autoflow. It checks the result against an arithmetic priority model. Directed sequences then walk the transmit-empty flag through its set, read-clear, load-clear and re-arm steps. They also count timeout ticks to the exact threshold and check the priority of code 2 over code 6.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int LVL_W     = 5,
  parameter int TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_rx_data,
  input  logic             en_tx_empty,
  input  logic             en_line,
  input  logic             en_modem,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_code,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic [3:0]       line_flags,
  input  logic             tx_empty,
  input  logic             tx_load,
  input  logic             iir_rd,
  input  logic [3:0]       modem_delta,
  input  logic             afe_en,
  output logic [7:0]       iir,
  output logic             irq
);
  localparam int CW = $clog2(TMO_CHARS + 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CHARS);

  logic [LVL_W-1:0] thr;
  always_comb begin
    case (trig_code)
      2'd0:    thr = LVL_W'(1);
      2'd1:    thr = LVL_W'(4);
      2'd2:    thr = LVL_W'(8);
      default: thr = LVL_W'(14);
    endcase
  end

  wire lvl_nz = (rx_level != '0);
  wire rx_hit = fifo_mode ? (rx_level >= thr) : lvl_nz;

  logic [CW-1:0] idle_cnt;
  wire rx_active = rx_push | rx_pop | !lvl_nz | !fifo_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                idle_cnt <= '0;
    else if (rx_active)                        idle_cnt <= '0;
    else if (char_tick && idle_cnt != TMO_LAST) idle_cnt <= idle_cnt + 1'b1;
  end

  wire tmo_hit = fifo_mode && lvl_nz && (idle_cnt == TMO_LAST);

  logic arm_q, thre_q;
  wire  arm      = tx_empty & en_tx_empty;
  wire  arm_rise = arm & ~arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      arm_q <= arm;
      if (tx_load)       thre_q <= 1'b0;
      else if (arm_rise) thre_q <= 1'b1;
      else if (iir_rd)   thre_q <= 1'b0;
    end
  end

  wire src_line  = en_line & (|line_flags);
  wire src_rx    = en_rx_data & rx_hit;
  wire src_tmo   = en_rx_data & tmo_hit;
  wire src_tx    = en_tx_empty & thre_q;
  wire src_modem = en_modem & ((|modem_delta[3:1]) | (modem_delta[0] & ~afe_en));

  logic [2:0] intid;
  always_comb begin
    if (src_line)     intid = 3'd3;
    else if (src_rx)  intid = 3'd2;
    else if (src_tmo) intid = 3'd6;
    else if (src_tx)  intid = 3'd1;
    else              intid = 3'd0;
  end

  assign irq = src_line | src_rx | src_tmo | src_tx | src_modem;
  assign iir = {fifo_mode ? 2'b11 : 2'b00, 2'b00, intid, ~irq};

  assert_quiet_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx_data && !en_tx_empty && !en_line && !en_modem) |-> (iir[0] && !irq));

  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_line && line_flags != 4'd0) |-> (iir[3:1] == 3'd3));

  assert_no_timeout_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> (iir[3:1] != 3'd6));

  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (iir[3:1] != 3'd1));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !arm_rise) |=> !thre_q);

  assert_mode_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[7:6] == {2{fifo_mode}}) && (iir[5:4] == 2'b00));

  assert_line_matches_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq != iir[0]);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_rx, en_tx, en_ln, en_md, fifo;
  logic [1:0] trig;
  logic [4:0] lvl;
  logic push, pop, tick, txe, load, rd, afe;
  logic [3:0] lf, md;
  logic [7:0] iir;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ident #(.LVL_W(5), .TMO_CHARS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_rx_data(en_rx), .en_tx_empty(en_tx),
    .en_line(en_ln), .en_modem(en_md), .fifo_mode(fifo), .trig_code(trig),
    .rx_level(lvl), .rx_push(push), .rx_pop(pop), .char_tick(tick),
    .line_flags(lf), .tx_empty(txe), .tx_load(load), .iir_rd(rd),
    .modem_delta(md), .afe_en(afe), .iir(iir), .irq(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(logic er, logic et, logic el, logic em,
      logic f, logic [1:0] t, int v, logic [3:0] l, logic [3:0] m, logic a,
      logic thre, logic tmo);
    int th;
    logic pl, prx, ptm, ptx, pm;
    logic [2:0] code;
    th  = (t == 0) ? 1 : (t == 3) ? 14 : 4 * t;
    pl  = el && l != 0;
    prx = er && (f ? v >= th : v != 0);
    ptm = er && f && v != 0 && tmo;
    ptx = et && thre;
    pm  = em && (m[3:1] != 0 || (m[0] && !a));
    code = pl ? 3'd3 : prx ? 3'd2 : ptm ? 3'd6 : ptx ? 3'd1 : 3'd0;
    return {f ? 2'b11 : 2'b00, 2'b00, code, ~(pl | prx | ptm | ptx | pm)};
  endfunction

  task automatic step();
    @(posedge clk); #1;
    push = 0; pop = 0; tick = 0; load = 0; rd = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    {en_rx, en_tx, en_ln, en_md, fifo, push, pop, tick, txe, load, rd, afe} = '0;
    trig = 0; lvl = 0; lf = 0; md = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    for (int e = 0; e < 16; e++)
      for (int l = 0; l < 2; l++)
        for (int f = 0; f < 2; f++)
          for (int t = 0; t < 4; t++)
            for (int v = 0; v <= 16; v++)
              for (int m = 0; m < 3; m++)
                for (int a = 0; a < 2; a++) begin
                  logic [7:0] exp;
                  string tag;
                  {en_md, en_ln, en_tx, en_rx} = 4'(e);
                  lf = l ? 4'(1 << (v % 4)) : 4'd0;
                  fifo = f[0]; trig = 2'(t); lvl = 5'(v); afe = a[0];
                  md = (m == 0) ? 4'd0 : (m == 1) ? 4'b0001 : 4'(2 << (v % 3));
                  @(negedge clk);
                  exp = model(en_rx, en_tx, en_ln, en_md, fifo, trig, v, lf, md, afe, 1'b0, 1'b0);
                  tag = (e == 0) ? "R2" : (exp[3:1] == 3) ? "R3" :
                        (exp[3:1] == 2) ? (f ? "R4" : "R5") :
                        (!exp[0]) ? "R8" : "R2";
                  chk(tag, iir, exp);
                  chk("R9", {6'd0, iir[7:6]}, f ? 8'd3 : 8'd0);
                  chk("R10", {7'd0, irq}, {7'd0, ~exp[0]});
                  @(posedge clk); #1;
                end

    {en_rx, en_tx, en_ln, en_md, fifo, afe} = '0;
    lf = 0; md = 0; lvl = 0; trig = 0;
    txe = 1; step();
    en_tx = 1; @(negedge clk);
    chk("R7 before set", iir, 8'h01);
    step(); @(negedge clk);
    chk("R7 set", iir, 8'h02);
    rd = 1; step(); @(negedge clk);
    chk("R7 read clears", iir, 8'h01);
    step(); step(); @(negedge clk);
    chk("R7 stays clear", iir, 8'h01);
    txe = 0; step();
    txe = 1; step(); @(negedge clk);
    chk("R7 rearm", iir, 8'h02);
    load = 1; step(); @(negedge clk);
    chk("R7 load clears", iir, 8'h01);
    en_tx = 0; txe = 0;

    fifo = 1; en_rx = 1; trig = 3; lvl = 2;
    push = 1; step();
    for (int k = 0; k < 3; k++) begin tick = 1; step(); end
    @(negedge clk);
    chk("R6 three ticks", iir, 8'hC1);
    tick = 1; step(); @(negedge clk);
    chk("R6 timeout", iir, 8'hCC);
    lvl = 15; @(negedge clk);
    chk("R6 code 2 over 6", iir, 8'hC4);
    lvl = 2; pop = 1; step(); @(negedge clk);
    chk("R6 pop clears", iir, 8'hC1);
    for (int k = 0; k < 4; k++) begin tick = 1; step(); end
    @(negedge clk);
    chk("R6 again", iir, 8'hCC);
    en_rx = 0; @(negedge clk);
    chk("R6 disabled", iir, 8'hC1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule